// File: doc/BRIEF.md
# Programmable Sync-Pattern Serial Framer

This block frames a synchronous serial link that is aligned either by bytes or transparently. Its receive half watches a serial bit stream, one bit per `rx_ce` pulse, and looks for a programmable sync pattern. Instead of a pattern it can also use an external carrier-detect line to find where a frame begins. Once the receiver has found that point it packs the following bits into bytes and delivers them. A run of sync characters that comes right after the lock point can optionally be removed from the delivered stream.

The transmit half advances one bit per `tx_ce` pulse. It sends the programmed sync field in front of every frame and then the frame bytes, which it takes from the byte handshake. Between frames it fills the line with either idle ones or repeated sync fields. It drives a request-to-send output that follows the chosen fill mode.

A single 2-bit length code controls both directions. Code 00 selects external sync. Codes 01, 10 and 11 select a 4, 8 or 16-bit sync field, which is taken from the low-order bits of `sync_reg`.

Top module: `sync_framer`

## Requirements
- R1: After reset, `rx_locked`, `rx_valid`, `rts` and `tx_ready` are 0 and `tx_bit` is 1.
- R2: With `sync_len` = 01, 10 or 11, the receiver compares the last 4, 8 or 16 received bits with `sync_reg[3:0]`, `[7:0]` or `[15:0]` at every `rx_ce`. The earliest received bit is compared with the highest pattern bit, and bits of `sync_reg` above the field have no effect. `rx_locked` goes to 1 after the edge that takes in the last pattern bit, and not before. The next bit is the MSB of the first byte, and bytes are assembled MSB first. `rx_valid` pulses for one clock with `rx_data` after the edge that takes in the eighth bit.
- R3: With `sync_len` = 00 and `rsyn` = 0, a stream equal to `sync_reg` does not lock the receiver. The receiver locks on the first `rx_ce` at which `cd` is 1, and that bit is the MSB of the first byte. While the receiver is locked, an `rx_ce` with `cd` = 0 returns it to hunting and discards the partial byte.
- R4: With `sync_len` = 00 and `rsyn` = 1, the first bit sampled with `cd` = 1 is the second bit of the frame. The bit sampled just before it becomes the MSB of the first byte.
- R5: With `strip_en` = 1, bytes equal to `strip_char` that arrive directly after lock are not delivered. The first byte that differs is delivered and ends stripping, so later bytes equal to `strip_char` are delivered.
- R6: `rx_en` = 0 clears the lock, the partial byte and the bit history, and no `rx_valid` follows. A fresh full pattern is needed to lock again.
- R7: For codes 01, 10 and 11, every frame begins with the sync field sent from its top bit down to bit 0. Code 00 sends no preamble. Frame bytes follow MSB first, and the byte presented with `tx_last` = 1 is the final byte of the frame.
- R8: `tx_ready` is 1 only in a cycle with `tx_ce` = 1 in which a byte is needed. A byte is taken when `tx_valid` and `tx_ready` are both 1. The first bit of a taken byte or of a started preamble appears on `tx_bit` after that edge.
- R9: With `rts_mode` = 0, idle ones are sent between frames and `rts` is 0 between frames. `rts` is 1 from the first preamble or data bit until the last data bit.
- R10: With `rts_mode` = 1, the sync field is sent repeatedly between frames (ones for code 00) and `rts` equals `en`. A change of `rts_mode` takes effect on `rts` in the same cycle.
- R11: With `en` = 0, `tx_bit` is 1, `rts` is 0 and `tx_ready` is 0, and any frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable (both directions) |
| rx_en | input | 1 | Receive enable; low forces hunting |
| sync_len | input | 2 | 00 external sync, 01 4-bit, 10 8-bit, 11 16-bit |
| sync_reg | input | 16 | Sync pattern, low-order aligned |
| rts_mode | input | 1 | 0 idle fill with RTS dropped; 1 sync fill with RTS held |
| rsyn | input | 1 | External sync: cd marks the second frame bit |
| strip_en | input | 1 | Remove leading sync characters |
| strip_char | input | 8 | Character to remove after lock |
| rx_bit | input | 1 | Serial receive data |
| rx_ce | input | 1 | Receive bit strobe |
| cd | input | 1 | Carrier detect |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_locked | output | 1 | Receiver is synchronized |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_last | input | 1 | Offered byte ends the frame |
| tx_ce | input | 1 | Transmit bit strobe |
| tx_ready | output | 1 | Offered byte is taken this cycle |
| tx_bit | output | 1 | Serial transmit data |
| rts | output | 1 | Request to send |

## Verification
The checks assume that `rx_valid` and lock changes only follow an `rx_ce` edge, and that `tx_ready` is never seen without `tx_ce` and `en`. Both strobes are therefore treated as single-cycle pulses. The stimulus changes every input at the falling clock edge and separates each strobe pulse with an idle cycle. The byte source holds `tx_data`, `tx_valid` and `tx_last` steady until it sees `tx_ready`. The length code, patterns and strip settings change only between scenarios, with `rx_en` or `en` pulsed low. `rts_mode` is the one setting changed while the channel runs, to exercise its immediate effect.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int SYNC_W = 16;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(SYNC_W + 1);

    typedef enum logic [1:0] {
        SL_EXT = 2'b00,
        SL_4   = 2'b01,
        SL_8   = 2'b10,
        SL_16  = 2'b11
    } sync_len_e;

    typedef enum logic [1:0] {
        TX_GAP  = 2'b00,
        TX_PRE  = 2'b01,
        TX_DATA = 2'b10
    } tx_state_e;

    typedef struct packed {
        logic [SYNC_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              last;
        tx_state_e         st;
    } tx_reg_t;

    // number of pattern bits for a length code
    function automatic logic [CNT_W-1:0] sync_bits(sync_len_e l);
        case (l)
            SL_4:    return CNT_W'(4);
            SL_8:    return CNT_W'(8);
            SL_16:   return CNT_W'(16);
            default: return '0;
        endcase
    endfunction

    // compare received history against the low-order pattern field
    function automatic logic sync_hit(logic [SYNC_W-1:0] hist,
                                      logic [SYNC_W-1:0] pat,
                                      sync_len_e l);
        case (l)
            SL_4:    return hist[3:0] == pat[3:0];
            SL_8:    return hist[7:0] == pat[7:0];
            SL_16:   return hist == pat;
            default: return 1'b0;
        endcase
    endfunction

    // left-align the pattern field so its top bit leaves first
    function automatic logic [SYNC_W-1:0] sync_left(logic [SYNC_W-1:0] pat,
                                                    sync_len_e l);
        case (l)
            SL_4:    return {pat[3:0], 12'b0};
            SL_8:    return {pat[7:0], 8'b0};
            SL_16:   return pat;
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/sfr_rx.sv
module sfr_rx
    import sfr_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  sync_len_e         len,
    input  logic              rsyn,
    input  logic              strip_en,
    input  logic [BW-1:0]     strip_char,
    input  logic [SYNC_W-1:0] pat,
    input  logic              rx_bit,
    input  logic              rx_ce,
    input  logic              cd,
    output logic [BW-1:0]     rx_data,
    output logic              rx_valid,
    output logic              rx_locked
);

    localparam int BC_W = $clog2(BW) + 1;

    logic [SYNC_W-1:0] hist;
    logic [SYNC_W-1:0] hist_n;
    logic [CNT_W-1:0]  fill;
    logic [CNT_W:0]    fill_n;
    logic [CNT_W-1:0]  need;
    logic [BC_W-1:0]   bitcnt;
    logic [BW-1:0]     acc;
    logic [BW-1:0]     acc_n;
    logic              strip_ph;
    logic              hit;

    always_comb begin
        hist_n = {hist[SYNC_W-2:0], rx_bit};
        fill_n = {1'b0, fill} + 1'b1;
        need   = sync_bits(len);
        acc_n  = {acc[BW-2:0], rx_bit};
        hit    = (fill_n >= {1'b0, need}) && sync_hit(hist_n, pat, len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist      <= '0;
            fill      <= '0;
            bitcnt    <= '0;
            acc       <= '0;
            strip_ph  <= 1'b0;
            rx_locked <= 1'b0;
            rx_valid  <= 1'b0;
            rx_data   <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!run) begin
                hist      <= '0;
                fill      <= '0;
                bitcnt    <= '0;
                acc       <= '0;
                rx_locked <= 1'b0;
            end else if (rx_ce) begin
                hist <= hist_n;
                if (fill < CNT_W'(SYNC_W))
                    fill <= fill + 1'b1;
                if (!rx_locked) begin
                    if (len == SL_EXT) begin
                        if (cd) begin
                            rx_locked <= 1'b1;
                            strip_ph  <= 1'b1;
                            if (rsyn) begin
                                acc    <= {{(BW-2){1'b0}}, hist[0], rx_bit};
                                bitcnt <= BC_W'(2);
                            end else begin
                                acc    <= {{(BW-1){1'b0}}, rx_bit};
                                bitcnt <= BC_W'(1);
                            end
                        end
                    end else if (hit) begin
                        rx_locked <= 1'b1;
                        strip_ph  <= 1'b1;
                        bitcnt    <= '0;
                        acc       <= '0;
                    end
                end else if (len == SL_EXT && !cd) begin
                    rx_locked <= 1'b0;
                    bitcnt    <= '0;
                    acc       <= '0;
                end else if (bitcnt == BC_W'(BW - 1)) begin
                    bitcnt <= '0;
                    acc    <= '0;
                    if (!(strip_en && strip_ph && acc_n == strip_char)) begin
                        rx_data  <= acc_n;
                        rx_valid <= 1'b1;
                        strip_ph <= 1'b0;
                    end
                end else begin
                    acc    <= acc_n;
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sfr_tx.sv
module sfr_tx
    import sfr_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  sync_len_e         len,
    input  logic              rts_mode,
    input  logic [SYNC_W-1:0] pat,
    input  logic [BW-1:0]     tx_data,
    input  logic              tx_valid,
    input  logic              tx_last,
    input  logic              tx_ce,
    output logic              tx_ready,
    output logic              tx_bit,
    output logic              rts
);

    tx_reg_t q;
    tx_reg_t d;
    logic    unit_end;
    logic    has_sync;
    logic    want_byte;
    logic    take;
    logic [SYNC_W-1:0] pre;
    logic [CNT_W-1:0]  need;

    always_comb begin
        unit_end  = (q.cnt <= CNT_W'(1));
        has_sync  = (len != SL_EXT);
        pre       = sync_left(pat, len);
        need      = sync_bits(len);
        want_byte = (q.st == TX_PRE)
                 || (q.st == TX_DATA && !q.last)
                 || (q.st == TX_GAP && !has_sync);
        tx_ready  = en && tx_ce && unit_end && want_byte;
        take      = tx_ready && tx_valid;
    end

    always_comb begin
        d      = q;
        d.sh   = {q.sh[SYNC_W-2:0], 1'b1};
        d.cnt  = q.cnt - 1'b1;
        if (unit_end) begin
            if (take) begin
                d.st   = TX_DATA;
                d.sh   = {tx_data, {(SYNC_W-BW){1'b0}}};
                d.cnt  = CNT_W'(BW);
                d.last = tx_last;
            end else if (q.st == TX_GAP && tx_valid && has_sync) begin
                d.st   = TX_PRE;
                d.sh   = pre;
                d.cnt  = need;
                d.last = 1'b0;
            end else begin
                d.st   = TX_GAP;
                d.last = 1'b0;
                if (rts_mode && has_sync) begin
                    d.sh  = pre;
                    d.cnt = need;
                end else begin
                    d.sh  = {1'b1, {(SYNC_W-1){1'b0}}};
                    d.cnt = CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            q.st   <= TX_GAP;
            q.sh   <= '1;
            q.cnt  <= CNT_W'(1);
            q.last <= 1'b0;
        end else if (tx_ce) begin
            q <= d;
        end
    end

    assign tx_bit = q.sh[SYNC_W-1];
    assign rts    = en && (rts_mode || q.st != TX_GAP);

endmodule

// File: rtl/sync_framer.sv
module sync_framer
    import sfr_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              rx_en,
    input  logic [1:0]        sync_len,
    input  logic [SYNC_W-1:0] sync_reg,
    input  logic              rts_mode,
    input  logic              rsyn,
    input  logic              strip_en,
    input  logic [BW-1:0]     strip_char,
    input  logic              rx_bit,
    input  logic              rx_ce,
    input  logic              cd,
    output logic [BW-1:0]     rx_data,
    output logic              rx_valid,
    output logic              rx_locked,
    input  logic [BW-1:0]     tx_data,
    input  logic              tx_valid,
    input  logic              tx_last,
    input  logic              tx_ce,
    output logic              tx_ready,
    output logic              tx_bit,
    output logic              rts
);

    sync_len_e len;
    logic      rx_run;

    assign len    = sync_len_e'(sync_len);
    assign rx_run = en && rx_en;

    sfr_rx #(.BW(BW)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .run        (rx_run),
        .len        (len),
        .rsyn       (rsyn),
        .strip_en   (strip_en),
        .strip_char (strip_char),
        .pat        (sync_reg),
        .rx_bit     (rx_bit),
        .rx_ce      (rx_ce),
        .cd         (cd),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_locked  (rx_locked)
    );

    sfr_tx #(.BW(BW)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .len      (len),
        .rts_mode (rts_mode),
        .pat      (sync_reg),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_last  (tx_last),
        .tx_ce    (tx_ce),
        .tx_ready (tx_ready),
        .tx_bit   (tx_bit),
        .rts      (rts)
    );

endmodule

// File: rtl/sfr_chk.sv
module sfr_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic rx_en,
    input logic rts_mode,
    input logic rx_ce,
    input logic rx_valid,
    input logic rx_locked,
    input logic tx_ce,
    input logic tx_ready,
    input logic tx_bit,
    input logic rts
);

    // R2
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(rx_locked));

    // R2
    valid_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(rx_ce));

    // R2
    lock_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_locked) |-> $past(rx_ce));

    // R6
    rx_off_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!rx_locked && !rx_valid));

    // R8
    ready_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (tx_ce && en));

    // R10
    rts_held_chk: assert property (@(posedge clk) disable iff (rst)
        (rts_mode && en) |-> rts);

    // R11
    rts_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !rts);

    // R11
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> tx_bit);

endmodule

bind sync_framer sfr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .rx_en     (rx_en),
    .rts_mode  (rts_mode),
    .rx_ce     (rx_ce),
    .rx_valid  (rx_valid),
    .rx_locked (rx_locked),
    .tx_ce     (tx_ce),
    .tx_ready  (tx_ready),
    .tx_bit    (tx_bit),
    .rts       (rts)
);

// File: tb/sync_framer_tb.sv
`timescale 1ns/1ps
module sync_framer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        rx_en = 1'b0;
    logic [1:0]  sync_len = 2'b00;
    logic [15:0] sync_reg = '0;
    logic        rts_mode = 1'b0;
    logic        rsyn = 1'b0;
    logic        strip_en = 1'b0;
    logic [7:0]  strip_char = '0;
    logic        rx_bit = 1'b0;
    logic        rx_ce = 1'b0;
    logic        cd = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_locked;
    logic [7:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_last = 1'b0;
    logic        tx_ce = 1'b0;
    logic        tx_ready;
    logic        tx_bit;
    logic        rts;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] got [0:15];
    int ngot = 0;

    always #5 clk = ~clk;

    sync_framer u_dut (
        .clk(clk), .rst(rst), .en(en), .rx_en(rx_en), .sync_len(sync_len),
        .sync_reg(sync_reg), .rts_mode(rts_mode), .rsyn(rsyn),
        .strip_en(strip_en), .strip_char(strip_char), .rx_bit(rx_bit),
        .rx_ce(rx_ce), .cd(cd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_locked(rx_locked), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_last(tx_last), .tx_ce(tx_ce), .tx_ready(tx_ready),
        .tx_bit(tx_bit), .rts(rts)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid && ngot < 16) begin
            got[ngot] = rx_data;
            ngot = ngot + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rxb(input logic b);
        @(negedge clk);
        rx_bit = b;
        rx_ce = 1'b1;
        @(negedge clk);
        rx_ce = 1'b0;
    endtask

    task automatic rxbyte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) rxb(b[i]);
    endtask

    task automatic rx_restart(input logic [1:0] code, input logic [15:0] pat);
        @(negedge clk);
        rx_en = 1'b0;
        sync_len = code;
        sync_reg = pat;
        @(negedge clk);
        rx_en = 1'b1;
        ngot = 0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 rx_locked", int'(rx_locked), 0);
        chk("R1 rx_valid", int'(rx_valid), 0);
        chk("R1 tx_bit", int'(tx_bit), 1);
        chk("R1 rts", int'(rts), 0);
        chk("R1 tx_ready", int'(tx_ready), 0);
    endtask

    // R2: hunt on a pattern of n bits held in the low bits of reg_val
    task automatic test_hunt(input logic [1:0] code, input logic [15:0] reg_val,
                             input int n, input string tag);
        rx_restart(code, reg_val);
        for (int i = 0; i < 6; i++) rxb(1'b0);
        for (int i = n - 1; i >= 1; i--) rxb(reg_val[i]);
        chk({tag, " not locked before last bit"}, int'(rx_locked), 0);
        rxb(reg_val[0]);
        chk({tag, " locked"}, int'(rx_locked), 1);
        rxbyte(8'h3C);
        rxbyte(8'hA5);
        repeat (2) @(negedge clk);
        chk({tag, " byte count"}, ngot, 2);
        chk({tag, " byte0"}, int'(got[0]), 8'h3C);
        chk({tag, " byte1"}, int'(got[1]), 8'hA5);
    endtask

    task automatic test_strip();
        strip_en = 1'b1;
        strip_char = 8'h96;
        rx_restart(2'b10, 16'h0096);
        for (int i = 0; i < 4; i++) rxb(1'b0);
        rxbyte(8'h96);
        rxbyte(8'h96);
        rxbyte(8'h96);
        rxbyte(8'h41);
        rxbyte(8'h96);
        repeat (2) @(negedge clk);
        chk("R5 delivered count", ngot, 2);
        chk("R5 first kept", int'(got[0]), 8'h41);
        chk("R5 later sync kept", int'(got[1]), 8'h96);
        strip_en = 1'b0;
    endtask

    task automatic test_rx_off();
        rx_restart(2'b10, 16'h0096);
        rxbyte(8'h96);
        rxb(1'b1);
        rxb(1'b0);
        rxb(1'b1);
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R6 unlocked", int'(rx_locked), 0);
        rx_en = 1'b1;
        rxbyte(8'h96);
        chk("R6 relocked", int'(rx_locked), 1);
        rxbyte(8'h5E);
        repeat (2) @(negedge clk);
        chk("R6 count", ngot, 1);
        chk("R6 byte", int'(got[0]), 8'h5E);
    endtask

    task automatic test_ext();
        rsyn = 1'b0;
        cd = 1'b0;
        rx_restart(2'b00, 16'h00FF);
        rxbyte(8'hFF);
        rxbyte(8'hFF);
        chk("R3 pattern ignored", int'(rx_locked), 0);
        cd = 1'b1;
        rxbyte(8'hC3);
        chk("R3 locked on cd", int'(rx_locked), 1);
        cd = 1'b0;
        rxb(1'b1);
        chk("R3 cd low unlocks", int'(rx_locked), 0);
        cd = 1'b1;
        rxbyte(8'h81);
        repeat (2) @(negedge clk);
        chk("R3 count", ngot, 2);
        chk("R3 byte0", int'(got[0]), 8'hC3);
        chk("R3 byte after relock", int'(got[1]), 8'h81);
        // R4: cd arrives with the second frame bit
        cd = 1'b0;
        rsyn = 1'b1;
        rx_restart(2'b00, 16'h0000);
        rxb(1'b0);
        rxb(1'b1);
        cd = 1'b1;
        rxb(1'b0);
        rxb(1'b1);
        rxb(1'b1);
        rxb(1'b0);
        rxb(1'b1);
        rxb(1'b1);
        rxb(1'b0);
        rxbyte(8'h7E);
        repeat (2) @(negedge clk);
        chk("R4 count", ngot, 2);
        chk("R4 aligned byte", int'(got[0]), 8'hB6);
        chk("R4 next byte", int'(got[1]), 8'h7E);
        cd = 1'b0;
        rsyn = 1'b0;
    endtask

    // R7 R8 R9 R10: one frame from a fresh gap state
    task automatic tx_run(input logic [1:0] code, input logic [15:0] pat,
                          input logic mode, input int nb, input logic [31:0] bytes,
                          input int ngap, input string tag);
        int n;
        int total;
        int idx;
        int bad_bits;
        int bad_rts;
        int bad_rdy;
        int taken;
        logic rdy;
        logic exp_b;
        n = (code == 2'b01) ? 4 : (code == 2'b10) ? 8 : (code == 2'b11) ? 16 : 0;
        total = n + 8 * nb;
        bad_bits = 0;
        bad_rts = 0;
        bad_rdy = 0;
        taken = 0;
        idx = 0;
        @(negedge clk);
        en = 1'b0;
        sync_len = code;
        sync_reg = pat;
        rts_mode = mode;
        @(negedge clk);
        en = 1'b1;
        for (int t = 0; t < total + ngap; t++) begin
            tx_valid = (idx < nb);
            tx_data = bytes[31 - 8 * idx -: 8];
            tx_last = (idx == nb - 1);
            @(negedge clk);
            if (tx_ready) bad_rdy++;
            tx_ce = 1'b1;
            #1;
            rdy = tx_ready;
            @(negedge clk);
            tx_ce = 1'b0;
            if (rdy && tx_valid) begin
                taken++;
                idx++;
            end
            if (t < n) exp_b = pat[n - 1 - t];
            else if (t < total) exp_b = bytes[31 - 8 * ((t - n) / 8) - ((t - n) % 8)];
            else if (mode && n > 0) exp_b = pat[n - 1 - ((t - total) % n)];
            else exp_b = 1'b1;
            if (tx_bit != exp_b) bad_bits++;
            if (rts != ((t < total) || mode)) bad_rts++;
        end
        tx_valid = 1'b0;
        tx_last = 1'b0;
        chk({tag, " R7 bit errors"}, bad_bits, 0);
        chk({tag, " R8 bytes taken"}, taken, nb);
        chk({tag, " R8 ready without strobe"}, bad_rdy, 0);
        if (mode) chk({tag, " R10 rts errors"}, bad_rts, 0);
        else chk({tag, " R9 rts errors"}, bad_rts, 0);
    endtask

    task automatic test_rts_fly();
        @(negedge clk);
        rts_mode = 1'b1;
        #1;
        chk("R10 rts follows mode 1", int'(rts), 1);
        rts_mode = 1'b0;
        #1;
        chk("R10 rts follows mode 0", int'(rts), 0);
    endtask

    task automatic test_disable();
        @(negedge clk);
        en = 1'b0;
        sync_len = 2'b10;
        sync_reg = 16'h0000;
        rts_mode = 1'b0;
        @(negedge clk);
        en = 1'b1;
        tx_valid = 1'b1;
        tx_data = 8'h00;
        tx_last = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            tx_ce = 1'b1;
            @(negedge clk);
            tx_ce = 1'b0;
        end
        chk("R11 frame running", int'(rts), 1);
        en = 1'b0;
        tx_ce = 1'b1;
        #1;
        chk("R11 ready held low", int'(tx_ready), 0);
        @(negedge clk);
        tx_ce = 1'b0;
        chk("R11 line idle", int'(tx_bit), 1);
        chk("R11 rts low", int'(rts), 0);
        tx_valid = 1'b0;
        tx_last = 1'b0;
        en = 1'b1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        en = 1'b1;
        test_reset();
        test_hunt(2'b01, 16'h5A0B, 4, "R2 4-bit");
        test_hunt(2'b10, 16'hC396, 8, "R2 8-bit");
        test_hunt(2'b11, 16'hEB90, 16, "R2 16-bit");
        test_strip();
        test_rx_off();
        test_ext();
        tx_run(2'b11, 16'hEB90, 1'b0, 2, 32'hA53C0000, 6, "16-bit mode0");
        tx_run(2'b10, 16'h1296, 1'b1, 1, 32'h71000000, 16, "8-bit mode1");
        tx_run(2'b01, 16'h7A05, 1'b1, 3, 32'hC3E10F00, 8, "4-bit mode1");
        tx_run(2'b00, 16'hFFFF, 1'b0, 2, 32'h5AF00000, 5, "ext mode0");
        tx_run(2'b00, 16'h0000, 1'b1, 1, 32'h0F000000, 5, "ext mode1");
        test_rts_fly();
        test_disable();
        finish_run();
    end

endmodule